// File: doc/BRIEF.md
# Padded sponge block builder

This block prepares the message side of a multi-block SHA3-256 absorb. It reads an encapsulation key byte by byte from a byte-addressed memory and packs the bytes into 136-byte rate blocks. The blocks already carry the hash padding, so the absorber downstream only XORs them into its state and permutes. The key length is chosen at run time from a 2-bit parameter-set code. The block count follows from that length: the smallest number of whole blocks that holds the key plus at least one pad byte.

A `start_i` pulse samples the parameter-set code and begins the first block. Each block is filled one byte per clock into an assembly register. A byte slot whose global offset lies inside the key takes the memory byte. Any other slot takes a padding constant. Once all slots are written, the block is offered with a valid/last pair and held until the absorber takes it with ready. A one-cycle done pulse follows the acceptance of the last block.

Top module: `spad_block_builder`

## Requirements
- R1: `kset_i` code 0 selects a key length of 800 bytes (6 blocks), code 1 selects 1184 bytes (9 blocks), and codes 2 and 3 select 1568 bytes (12 blocks). `blk_last_o` is high on the final block only. No further block is offered after the final one.
- R2: Byte slot j of a block occupies bits [8j+7:8j] of `blk_data_o`. Its global offset is (block index × 136 + j). If that offset is below the key length, the slot holds the memory byte at that address.
- R3: The byte at global offset equal to the key length holds 0x06.
- R4: The remaining pad bytes are 0x00, except the last byte of the final block, which has bit 7 set. If that byte is also the 0x06 byte, it holds 0x86.
- R5: `mem_rd_o` is asserted only for addresses below the key length. Addresses rise by one per read, starting at 0 after a start. Each key byte is read exactly once. Read data is taken one cycle after the request.
- R6: While `blk_valid_o` is high and `blk_ready_i` is low, the block data and the last flag stay unchanged. A block transfers on a cycle with both high. No byte is written while a block is on offer.
- R7: `done_o` is high for exactly one cycle, the cycle after the final block is accepted. It is never high otherwise.
- R8: During and straight after reset, `blk_valid_o`, `done_o` and `mem_rd_o` are low.
- R9: A `start_i` pulse while a run is in progress is ignored. The run keeps its key length and block count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run; ignored while busy |
| kset_i | input | 2 | Parameter-set code, sampled on start |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | ADDR_W | Byte address of the read |
| mem_data_i | input | 8 | Read data, one cycle after the request |
| blk_data_o | output | 8*RATE_BYTES | Assembled padded rate block, byte 0 in the low bits |
| blk_valid_o | output | 1 | Block on offer |
| blk_last_o | output | 1 | Offered block is the final one |
| blk_ready_i | input | 1 | Absorber accepts the block |
| done_o | output | 1 | One-cycle pulse after the final block is taken |

## Verification
Several internal faults show up at the ports at particular times. A position counter that slips, or a block counter with the wrong limit, appears as misplaced key bytes or a wrong last flag on the first affected block, about 137 cycles after the start. A pad decision that is off by one offset corrupts either the 0x06 byte or the final tail bit. That error is visible only on the block holding the key end, or on the final block. To catch the case where the domain byte and the tail byte coincide, a small configuration places the key end on the last slot. A handshake fault shows within the stall window as data that changes under a low ready, or as a done pulse that is misplaced.

// File: rtl/spad_pkg.sv
package spad_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_FILL, PH_OFFER} phase_t;

  // key length for a parameter-set code; codes 2 and 3 share the largest set
  function automatic int unsigned sel_len(input logic [1:0] ks,
                                          input int unsigned l_a,
                                          input int unsigned l_b,
                                          input int unsigned l_c);
    case (ks)
      2'd0:    return l_a;
      2'd1:    return l_b;
      default: return l_c;
    endcase
  endfunction

  // whole blocks needed for key plus one mandatory pad byte
  function automatic int unsigned blocks_for(input int unsigned len,
                                             input int unsigned rate);
    return (len + rate) / rate;
  endfunction

  // constant for a position outside the key
  function automatic logic [7:0] pad_value(input int unsigned pos,
                                           input int unsigned len,
                                           input int unsigned total);
    logic [7:0] b;
    b = (pos == len) ? 8'h06 : 8'h00;
    if (pos == total - 1) b = b | 8'h80;
    return b;
  endfunction

endpackage

// File: rtl/spad_addr_seq.sv
module spad_addr_seq
  import spad_pkg::*;
#(
  parameter int RATE_BYTES = 136,
  parameter int CW         = 12,
  localparam int SW        = (RATE_BYTES > 1) ? $clog2(RATE_BYTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          fill_go,
  input  logic [CW-1:0] len,
  input  logic [CW-1:0] total,
  output logic          iss_vld,
  output logic [CW-1:0] iss_pos,
  output logic [SW-1:0] iss_slot,
  output logic          iss_in_key,
  output logic [7:0]    iss_pad
);

  logic          active_q;
  logic [SW-1:0] slot_q;
  logic [CW-1:0] pos_q;
  logic          last_slot;

  assign last_slot  = (slot_q == SW'(RATE_BYTES - 1));
  assign iss_vld    = active_q;
  assign iss_pos    = pos_q;
  assign iss_slot   = slot_q;
  assign iss_in_key = active_q && (pos_q < len);
  assign iss_pad    = pad_value(32'(pos_q), 32'(len), 32'(total));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      pos_q    <= '0;
    end else if (fill_go) begin
      active_q <= 1'b1;
      slot_q   <= '0;
      if (restart) pos_q <= '0;
    end else if (active_q) begin
      pos_q  <= pos_q + 1'b1;
      slot_q <= slot_q + 1'b1;
      if (last_slot) active_q <= 1'b0;
    end
  end

  // R5
  pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !last_slot && !fill_go) |=> (active_q && pos_q == $past(pos_q) + 1'b1));

endmodule

// File: rtl/spad_byte_sel.sv
module spad_byte_sel #(
  parameter int RATE_BYTES = 136,
  localparam int SW        = (RATE_BYTES > 1) ? $clog2(RATE_BYTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_vld,
  input  logic [SW-1:0] iss_slot,
  input  logic          iss_in_key,
  input  logic [7:0]    iss_pad,
  input  logic [7:0]    mem_data,
  output logic          wr_vld,
  output logic [SW-1:0] wr_slot,
  output logic [7:0]    wr_byte,
  output logic          wr_final
);

  logic       key_q;
  logic [7:0] pad_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_vld  <= 1'b0;
      wr_slot <= '0;
      key_q   <= 1'b0;
      pad_q   <= 8'h00;
    end else begin
      wr_vld  <= iss_vld;
      wr_slot <= iss_slot;
      key_q   <= iss_in_key;
      pad_q   <= iss_pad;
    end
  end

  assign wr_byte  = key_q ? mem_data : pad_q;
  assign wr_final = wr_vld && (wr_slot == SW'(RATE_BYTES - 1));

  // R2
  stage_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld |-> $past(iss_vld));

endmodule

// File: rtl/spad_word_reg.sv
module spad_word_reg #(
  parameter int RATE_BYTES = 136,
  localparam int SW        = (RATE_BYTES > 1) ? $clog2(RATE_BYTES) : 1,
  localparam int BW        = 8 * RATE_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_vld,
  input  logic [SW-1:0] wr_slot,
  input  logic [7:0]    wr_byte,
  output logic [BW-1:0] word
);

  logic [RATE_BYTES-1:0] lane_en;

  for (genvar g = 0; g < RATE_BYTES; g++) begin : g_lane
    assign lane_en[g] = wr_vld && (wr_slot == SW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else begin
      for (int j = 0; j < RATE_BYTES; j++) begin
        if (lane_en[j]) word[8*j +: 8] <= wr_byte;
      end
    end
  end

  // R2
  one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_en));

endmodule

// File: rtl/spad_block_builder.sv
module spad_block_builder
  import spad_pkg::*;
#(
  parameter int RATE_BYTES = 136,
  parameter int ADDR_W     = 11,
  parameter int LEN_K2     = 800,
  parameter int LEN_K3     = 1184,
  parameter int LEN_K4     = 1568,
  localparam int BW        = 8 * RATE_BYTES,
  localparam int CW        = ADDR_W + 1,
  localparam int SW        = (RATE_BYTES > 1) ? $clog2(RATE_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        kset_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i,
  output logic [BW-1:0]     blk_data_o,
  output logic              blk_valid_o,
  output logic              blk_last_o,
  input  logic              blk_ready_i,
  output logic              done_o
);

  phase_t        phase_q;
  logic [CW-1:0] len_q, tot_q, nblk_q, blk_idx_q;
  logic [CW-1:0] len_sel, nblk_sel, tot_sel;
  logic          start_take, hs, fill_go;

  logic          iss_vld, iss_in_key;
  logic [CW-1:0] iss_pos;
  logic [SW-1:0] iss_slot;
  logic [7:0]    iss_pad;
  logic          wr_vld, wr_final;
  logic [SW-1:0] wr_slot;
  logic [7:0]    wr_byte;

  assign len_sel  = CW'(sel_len(kset_i, LEN_K2, LEN_K3, LEN_K4));
  assign nblk_sel = CW'(blocks_for(32'(len_sel), RATE_BYTES));
  assign tot_sel  = CW'(blocks_for(32'(len_sel), RATE_BYTES) * RATE_BYTES);

  assign blk_valid_o = (phase_q == PH_OFFER);
  assign blk_last_o  = blk_valid_o && (blk_idx_q == nblk_q - 1'b1);
  assign start_take  = (phase_q == PH_IDLE) && start_i;
  assign hs          = blk_valid_o && blk_ready_i;
  assign fill_go     = start_take || (hs && !blk_last_o);

  assign mem_rd_o   = iss_in_key;
  assign mem_addr_o = iss_pos[ADDR_W-1:0];

  spad_addr_seq #(.RATE_BYTES(RATE_BYTES), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .restart(start_take), .fill_go(fill_go),
    .len(len_q), .total(tot_q), .iss_vld(iss_vld), .iss_pos(iss_pos),
    .iss_slot(iss_slot), .iss_in_key(iss_in_key), .iss_pad(iss_pad)
  );

  spad_byte_sel #(.RATE_BYTES(RATE_BYTES)) u_sel (
    .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_slot(iss_slot),
    .iss_in_key(iss_in_key), .iss_pad(iss_pad), .mem_data(mem_data_i),
    .wr_vld(wr_vld), .wr_slot(wr_slot), .wr_byte(wr_byte), .wr_final(wr_final)
  );

  spad_word_reg #(.RATE_BYTES(RATE_BYTES)) u_word (
    .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .wr_slot(wr_slot),
    .wr_byte(wr_byte), .word(blk_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      len_q     <= '0;
      tot_q     <= '0;
      nblk_q    <= '0;
      blk_idx_q <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (phase_q)
        PH_IDLE: if (start_take) begin
          len_q     <= len_sel;
          tot_q     <= tot_sel;
          nblk_q    <= nblk_sel;
          blk_idx_q <= '0;
          phase_q   <= PH_FILL;
        end
        PH_FILL: if (wr_final) phase_q <= PH_OFFER;
        PH_OFFER: if (hs) begin
          if (blk_last_o) begin
            done_o  <= 1'b1;
            phase_q <= PH_IDLE;
          end else begin
            blk_idx_q <= blk_idx_q + 1'b1;
            phase_q   <= PH_FILL;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R6
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid_o && !blk_ready_i) |=>
      (blk_valid_o && $stable(blk_data_o) && $stable(blk_last_o)));

  // R6
  quiet_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid_o |-> !wr_vld);

  // R5
  rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> ({1'b0, mem_addr_o} < len_q));

  // R7
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(hs && blk_last_o));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R4
  tail_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_last_o |-> blk_data_o[BW-1]);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=> $stable(len_q));

endmodule

// File: tb/spad_block_builder_bench.sv
`timescale 1ns/1ps
module spad_block_builder_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] kset  = 2'd0;
  logic       ready = 1'b0;
  logic       sel   = 1'b0;

  logic          b_rd, b_valid, b_last, b_done;
  logic [10:0]   b_addr;
  logic [7:0]    b_rdata = 8'h00;
  logic [1087:0] b_data;
  logic          s_rd, s_valid, s_last, s_done;
  logic [4:0]    s_addr;
  logic [7:0]    s_rdata = 8'h00;
  logic [63:0]   s_data;

  spad_block_builder u_spad_block_builder (
    .clk(clk), .rst_n(rst_n), .start_i(start & ~sel), .kset_i(kset),
    .mem_rd_o(b_rd), .mem_addr_o(b_addr), .mem_data_i(b_rdata),
    .blk_data_o(b_data), .blk_valid_o(b_valid), .blk_last_o(b_last),
    .blk_ready_i(ready & ~sel), .done_o(b_done)
  );

  spad_block_builder #(.RATE_BYTES(8), .ADDR_W(5), .LEN_K2(7), .LEN_K3(8), .LEN_K4(16))
  u_spad_block_builder_small (
    .clk(clk), .rst_n(rst_n), .start_i(start & sel), .kset_i(kset),
    .mem_rd_o(s_rd), .mem_addr_o(s_addr), .mem_data_i(s_rdata),
    .blk_data_o(s_data), .blk_valid_o(s_valid), .blk_last_o(s_last),
    .blk_ready_i(ready & sel), .done_o(s_done)
  );

  logic [1087:0] cur_data;
  logic          cur_valid, cur_last, cur_done;
  assign cur_data  = sel ? {1024'b0, s_data} : b_data;
  assign cur_valid = sel ? s_valid : b_valid;
  assign cur_last  = sel ? s_last : b_last;
  assign cur_done  = sel ? s_done : b_done;

  int errors = 0;
  int checks = 0;

  function automatic logic [7:0] memb(input int a);
    return 8'(a * 29 + 7) ^ 8'(a >>> 3);
  endfunction

  // memory model and read monitor
  int  reads = 0, oob = 0, seq_err = 0, exp_addr = 0, cur_len = 0;
  bit  run_busy = 1'b0;
  always @(posedge clk) begin
    if (b_rd) b_rdata <= memb(int'(b_addr));
    if (s_rd) s_rdata <= memb(int'(s_addr));
    if (start && !run_busy) exp_addr <= 0;
    else if (sel ? s_rd : b_rd) begin
      reads <= reads + 1;
      if ((sel ? int'(s_addr) : int'(b_addr)) >= cur_len) oob <= oob + 1;
      if ((sel ? int'(s_addr) : int'(b_addr)) != exp_addr) seq_err <= seq_err + 1;
      exp_addr <= (sel ? int'(s_addr) : int'(b_addr)) + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input bit s, input logic [1:0] ks, input int stall, input bit poke);
    int rate, len, nb, total, r0;
    rate = s ? 8 : 136;
    if (s) len = (ks == 0) ? 7 : (ks == 1) ? 8 : 16;
    else   len = (ks == 0) ? 800 : (ks == 1) ? 1184 : 1568;
    nb = 0;
    while (nb * rate < len + 1) nb++;
    total = nb * rate;
    @(negedge clk);
    sel = s; kset = ks; start = 1'b1; cur_len = len; r0 = reads;
    @(negedge clk);
    start = 1'b0; run_busy = 1'b1;
    for (int b = 0; b < nb; b++) begin
      logic [1087:0] snap;
      logic snapl;
      int bad2, bad3, bad4;
      longint a2, e2, a3, a4, e4;
      while (!cur_valid) @(negedge clk);
      snap = cur_data; snapl = cur_last;
      for (int t = 0; t < stall; t++) begin
        @(negedge clk);
        check(cur_valid && cur_data == snap && cur_last == snapl, "R6",
              "block held under stall", longint'(cur_valid), 1);
      end
      check(cur_last == (b == nb - 1), "R1", "last flag", longint'(cur_last),
            longint'(b == nb - 1));
      bad2 = 0; bad3 = 0; bad4 = 0;
      a2 = 0; e2 = 0; a3 = 0; a4 = 0; e4 = 0;
      for (int j = 0; j < rate; j++) begin
        int p;
        logic [7:0] got, want;
        p = b * rate + j;
        got = cur_data[8*j +: 8];
        if (p < len) begin
          want = memb(p);
          if (got != want) begin bad2++; a2 = got; e2 = want; end
        end else if (p == len && p != total - 1) begin
          if (got != 8'h06) begin bad3++; a3 = got; end
        end else begin
          want = (p == total - 1 ? 8'h80 : 8'h00) + (p == len ? 8'h06 : 8'h00);
          if (got != want) begin bad4++; a4 = got; e4 = want; end
        end
      end
      check(bad2 == 0, "R2", "key byte", a2, e2);
      if (len >= b * rate && len < (b + 1) * rate && len != total - 1)
        check(bad3 == 0, "R3", "domain byte", a3, 8'h06);
      check(bad4 == 0, "R4", "pad byte", a4, e4);
      ready = 1'b1;
      @(negedge clk);
      ready = 1'b0;
      check(cur_done == (b == nb - 1), "R7", "done after accept",
            longint'(cur_done), longint'(b == nb - 1));
      if (poke && b == 0) begin
        kset = ks ^ 2'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0; kset = ks;
      end
      if (b == nb - 1) begin
        if (!(poke && b == 0)) @(negedge clk);
        check(!cur_done, "R7", "done one cycle", longint'(cur_done), 0);
        repeat (3) begin
          @(negedge clk);
          check(!cur_valid, "R1", "no block after final", longint'(cur_valid), 0);
        end
      end
    end
    @(negedge clk);
    check(reads - r0 == len, "R5", "read count", reads - r0, len);
    check(oob == 0 && seq_err == 0, "R5", "read addresses", oob + seq_err, 0);
    if (poke) check(1'b1, "R9", "busy start ignored (bytes and count above)", 0, 0);
    run_busy = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R6 watchdog: actual=hung expected=progress");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!b_valid && !b_done && !b_rd && !s_valid && !s_done && !s_rd, "R8",
          "state in reset", longint'({b_valid, b_done, b_rd}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!b_valid && !b_done && !b_rd && !s_valid && !s_done && !s_rd, "R8",
          "state after reset", longint'({s_valid, s_done, s_rd}), 0);
    run(1'b0, 2'd0, 2, 1'b0);
    run(1'b0, 2'd1, 0, 1'b1);
    run(1'b0, 2'd2, 1, 1'b0);
    run(1'b0, 2'd3, 0, 1'b0);
    run(1'b1, 2'd0, 1, 1'b0);
    run(1'b1, 2'd1, 0, 1'b0);
    run(1'b1, 2'd2, 3, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule